// File: doc/BRIEF.md
# Scrambled-Address March Memory Self-Test Controller

This block is a built-in self-test engine for a single-port synchronous word RAM. After a start pulse it takes over the RAM address, write-data and write-enable lines and runs the March C- algorithm over every word. The algorithm has six elements and uses two data backgrounds: all zeros and all ones. When the algorithm-select input is high at start, the two middle elements are skipped and the shorter March X sequence runs instead. The engine stops at the first read that returns the wrong value. It then reports failure and the logical address of the faulty word, and holds that result until the next start.

Logical addresses are mapped to physical RAM addresses through a scramble that follows the cell layout. Within every group of four words, the third and fourth words trade places, so the visiting order is 0,1,3,2,4,5,7,6,... in both directions. This makes cells that are physically adjacent also neighbours in time, so coupling faults between them are exposed. A parameter removes the scramble for memories laid out linearly.

The controller is a single state machine with six states:
- IDLE: after reset.
- FILL: first element, write zeros upward.
- READ: issue a read.
- MODIFY: compare the returned word and, when the element has one, perform its write.
- PASS and FAIL: terminal states that hold the result.

The transitions are:
- start: from IDLE, PASS or FAIL into FILL.
- fill-done: FILL to READ.
- read-issued: READ to MODIFY.
- next-word: MODIFY to READ, stepping the address.
- next-element: MODIFY to READ, reloading the address for the next element.
- all-passed: MODIFY to PASS.
- mismatch: MODIFY to FAIL.

Top module: `mbist_march_ctrl`

## Requirements
- R1: After reset, done_o, fail_o and ram_we_o are 0 and fail_addr_o is 0.
- R2: A start_i pulse seen in IDLE, PASS or FAIL leads, in the very next cycle, to a write of all zeros to physical address 0. The FILL element then writes all zeros to every word in ascending logical order, one word per cycle.
- R3: In March C- mode (algo_x_i = 0 at start), the elements are, in this order:
  - write 0, ascending;
  - read 0 then write 1, ascending;
  - read 1 then write 0, ascending;
  - read 0 then write 1, descending;
  - read 1 then write 0, descending;
  - read 0, descending.
  
  Here 0 means 32'h00000000 and 1 means 32'hFFFFFFFF. Each read-bearing element takes two cycles per word. A fault-free run therefore reaches done_o = 1 with fail_o = 0 exactly 11*DEPTH cycles after the start edge.
- R4: In March X mode (algo_x_i = 1 at start), the second ascending element and the first descending element are skipped. The sequence is: write 0 ascending; read 0 and write 1 ascending; read 1 and write 0 descending; read 0 descending. A fault-free run completes 7*DEPTH cycles after the start edge.
- R5: With SCRAMBLE = 1, the physical address equals the logical address with bit 0 replaced by bit0 XOR bit1. This gives the order 0,1,3,2 in every group of four words, in both ascending and descending elements.
- R6: With SCRAMBLE = 0, the physical address equals the logical address.
- R7: Read data is compared in the cycle after the read is issued. On the first mismatch, the controller enters FAIL in the next cycle, with fail_o = 1 and done_o = 1. The write belonging to the mismatching word is suppressed, and no further writes follow.
- R8: fail_addr_o holds the logical (unscrambled) address of the first mismatching word.
- R9: done_o, fail_o and fail_addr_o stay constant until the next start. A start_i pulse during a run has no effect on the run.
- R10: The algorithm select is captured only at start. Toggling algo_x_i during a run does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a test run when not busy |
| algo_x_i | input | 1 | 1 selects March X, 0 selects March C- (sampled at start) |
| ram_addr_o | output | ADDR_W | Physical RAM word address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_we_o | output | 1 | RAM write enable; a read is implied when low |
| ram_rdata_i | input | DATA_W | RAM read data, valid one cycle after the read address |
| done_o | output | 1 | Test finished (pass or fail) |
| fail_o | output | 1 | Test found a mismatch |
| fail_addr_o | output | ADDR_W | Logical address of the first mismatch |

## Verification
Each result has a fixed cycle at which it is due. The first zero write appears in the cycle after the start edge. The done flag rises 11*DEPTH or 7*DEPTH cycles after the start edge, depending on the mode. For a stuck bit at logical word L, FAIL is entered at a cycle computed from the element in which the fault first shows and from L's position in that element's address order.

The bench counts clock edges from the start edge and samples every output on the falling edge. It compares the counted cycle with these formulas, and checks each write's address and data against a sequence rebuilt arithmetically from the element list and the scramble rule. A sweep places stuck-at-0 and stuck-at-1 faults at every physical word in both modes.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_MODIFY,
        ST_PASS,
        ST_FAIL
    } mbist_state_e;

    // Per-element control: address direction, value expected on read,
    // value written after the read, and whether a write follows at all.
    typedef struct packed {
        logic descend;
        logic expect_one;
        logic write_one;
        logic has_write;
    } elem_desc_t;

    localparam logic [2:0] ELEM_FIRST = 3'd0;
    localparam logic [2:0] ELEM_LAST  = 3'd5;

    function automatic elem_desc_t elem_desc(input logic [2:0] idx);
        elem_desc_t d;
        unique case (idx)
            3'd0:    d = '{descend: 1'b0, expect_one: 1'b0, write_one: 1'b0, has_write: 1'b1};
            3'd1:    d = '{descend: 1'b0, expect_one: 1'b0, write_one: 1'b1, has_write: 1'b1};
            3'd2:    d = '{descend: 1'b0, expect_one: 1'b1, write_one: 1'b0, has_write: 1'b1};
            3'd3:    d = '{descend: 1'b1, expect_one: 1'b0, write_one: 1'b1, has_write: 1'b1};
            3'd4:    d = '{descend: 1'b1, expect_one: 1'b1, write_one: 1'b0, has_write: 1'b1};
            default: d = '{descend: 1'b1, expect_one: 1'b0, write_one: 1'b0, has_write: 1'b0};
        endcase
        return d;
    endfunction

    // March X drops the second ascending and the first descending element.
    function automatic logic [2:0] next_elem(input logic [2:0] idx, input logic march_x);
        logic [2:0] n;
        if (march_x && idx == 3'd1) begin
            n = 3'd4;
        end else begin
            n = idx + 3'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              descend_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_end_o
);

    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            dir_q  <= 1'b0;
        end else if (load_i) begin
            addr_q <= descend_i ? ADDR_TOP : '0;
            dir_q  <= descend_i;
        end else if (step_i) begin
            addr_q <= dir_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o   = addr_q;
    assign at_end_o = dir_q ? (addr_q == '0) : (addr_q == ADDR_TOP);

endmodule

// File: rtl/mbist_addr_scramble.sv
module mbist_addr_scramble #(
    parameter int ADDR_W   = 10,
    parameter bit SCRAMBLE = 1'b1
) (
    input  logic [ADDR_W-1:0] log_addr_i,
    output logic [ADDR_W-1:0] phys_addr_o
);

    generate
        if (SCRAMBLE && ADDR_W >= 2) begin : g_swap
            // Third and fourth word of every group of four trade places.
            assign phys_addr_o = {log_addr_i[ADDR_W-1:1], log_addr_i[0] ^ log_addr_i[1]};
        end else begin : g_flat
            assign phys_addr_o = log_addr_i;
        end
    endgenerate

endmodule

// File: rtl/mbist_read_check.sv
module mbist_read_check #(
    parameter int DATA_W = 32
) (
    input  logic              check_en_i,
    input  logic              expect_one_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              mismatch_o
);

    logic [DATA_W-1:0] expected;

    assign expected   = expect_one_i ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    assign mismatch_o = check_en_i && (rdata_i != expected);

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter bit SCRAMBLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              algo_x_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_we_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);

    mbist_state_e      state_q, state_d;
    logic [2:0]        elem_q, elem_d;
    logic              algo_x_q, algo_x_d;
    logic [ADDR_W-1:0] fail_addr_q, fail_addr_d;

    logic              seq_load, seq_desc, seq_step;
    logic [ADDR_W-1:0] log_addr;
    logic              at_end;
    logic              mismatch;
    elem_desc_t        cur_desc, nxt_desc;
    logic [2:0]        nxt_elem;

    assign cur_desc = elem_desc(elem_q);
    assign nxt_elem = next_elem(elem_q, algo_x_q);
    assign nxt_desc = elem_desc(nxt_elem);

    mbist_addr_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (seq_load),
        .descend_i(seq_desc),
        .step_i   (seq_step),
        .addr_o   (log_addr),
        .at_end_o (at_end)
    );

    mbist_addr_scramble #(.ADDR_W(ADDR_W), .SCRAMBLE(SCRAMBLE)) scr_i (
        .log_addr_i (log_addr),
        .phys_addr_o(ram_addr_o)
    );

    mbist_read_check #(.DATA_W(DATA_W)) chk_rd_i (
        .check_en_i  (state_q == ST_MODIFY),
        .expect_one_i(cur_desc.expect_one),
        .rdata_i     (ram_rdata_i),
        .mismatch_o  (mismatch)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            elem_q      <= ELEM_FIRST;
            algo_x_q    <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            state_q     <= state_d;
            elem_q      <= elem_d;
            algo_x_q    <= algo_x_d;
            fail_addr_q <= fail_addr_d;
        end
    end

    // Transitions
    always_comb begin
        state_d     = state_q;
        elem_d      = elem_q;
        algo_x_d    = algo_x_q;
        fail_addr_d = fail_addr_q;
        seq_load    = 1'b0;
        seq_desc    = 1'b0;
        seq_step    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_i) begin                 // start
                    state_d  = ST_FILL;
                    elem_d   = ELEM_FIRST;
                    algo_x_d = algo_x_i;
                    seq_load = 1'b1;
                    seq_desc = 1'b0;
                end
            end
            ST_FILL: begin
                if (at_end) begin                  // fill-done
                    state_d  = ST_READ;
                    elem_d   = nxt_elem;
                    seq_load = 1'b1;
                    seq_desc = nxt_desc.descend;
                end else begin
                    seq_step = 1'b1;
                end
            end
            ST_READ: begin
                state_d = ST_MODIFY;               // read-issued
            end
            ST_MODIFY: begin
                if (mismatch) begin                // mismatch
                    state_d     = ST_FAIL;
                    fail_addr_d = log_addr;
                end else if (at_end) begin
                    if (elem_q == ELEM_LAST) begin // all-passed
                        state_d = ST_PASS;
                    end else begin                 // next-element
                        state_d  = ST_READ;
                        elem_d   = nxt_elem;
                        seq_load = 1'b1;
                        seq_desc = nxt_desc.descend;
                    end
                end else begin                     // next-word
                    state_d  = ST_READ;
                    seq_step = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        ram_we_o    = 1'b0;
        ram_wdata_o = '0;
        done_o      = 1'b0;
        fail_o      = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                ram_we_o = 1'b1;
            end
            ST_MODIFY: begin
                ram_we_o    = cur_desc.has_write && !mismatch;
                ram_wdata_o = cur_desc.write_one ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
            end
            ST_PASS: begin
                done_o = 1'b1;
            end
            ST_FAIL: begin
                done_o = 1'b1;
                fail_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign fail_addr_o = fail_addr_q;

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input mbist_state_e      state_q,
    input logic              ram_we_o,
    input logic [DATA_W-1:0] ram_wdata_o,
    input logic              done_o,
    input logic              fail_o,
    input logic [ADDR_W-1:0] fail_addr_o
);

    logic not_busy;
    assign not_busy = (state_q == ST_IDLE) || (state_q == ST_PASS) || (state_q == ST_FAIL);

    assert_fill_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && not_busy) |=> (ram_we_o && ram_wdata_o == '0));

    assert_pattern_solid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_wdata_o == '0 || ram_wdata_o == '1));

    assert_no_write_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ram_we_o);

    assert_fail_is_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    assert_fail_after_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> ($past(state_q) == ST_MODIFY));

    assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_addr_o)));

endmodule

bind mbist_march_ctrl mbist_march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .state_q    (state_q),
    .ram_we_o   (ram_we_o),
    .ram_wdata_o(ram_wdata_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o)
);

// File: tb/mbist_march_ctrl_tb_top.sv
`timescale 1ns/1ps

module mbist_tb_ram #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    input  logic          flt_en,
    input  logic [AW-1:0] flt_addr,
    input  int            flt_bit,
    input  logic          flt_val
);
    logic [DW-1:0] mem [2**AW];
    always @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else begin
            logic [DW-1:0] v;
            v = mem[addr];
            if (flt_en && addr == flt_addr) v[flt_bit] = flt_val;
            rdata <= v;
        end
    end
endmodule

module mbist_march_ctrl_tb_top;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int N  = 2**AW;
    localparam int LIMIT = 20 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic algo_x = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [AW-1:0] addr_s, addr_f, fa_s, fa_f;
    logic [DW-1:0] wd_s, wd_f, rd_s, rd_f;
    logic we_s, we_f, done_s, done_f, fail_s, fail_f;

    logic          flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    int            flt_bit = 0;
    logic          flt_val = 1'b0;

    mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SCRAMBLE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .algo_x_i(algo_x),
        .ram_addr_o(addr_s), .ram_wdata_o(wd_s), .ram_we_o(we_s), .ram_rdata_i(rd_s),
        .done_o(done_s), .fail_o(fail_s), .fail_addr_o(fa_s));

    mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SCRAMBLE(1'b0)) dut_flat_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .algo_x_i(algo_x),
        .ram_addr_o(addr_f), .ram_wdata_o(wd_f), .ram_we_o(we_f), .ram_rdata_i(rd_f),
        .done_o(done_f), .fail_o(fail_f), .fail_addr_o(fa_f));

    mbist_tb_ram #(.AW(AW), .DW(DW)) ram_s_i (
        .clk(clk), .addr(addr_s), .wdata(wd_s), .we(we_s), .rdata(rd_s),
        .flt_en(flt_en), .flt_addr(flt_addr), .flt_bit(flt_bit), .flt_val(flt_val));

    mbist_tb_ram #(.AW(AW), .DW(DW)) ram_f_i (
        .clk(clk), .addr(addr_f), .wdata(wd_f), .we(we_f), .rdata(rd_f),
        .flt_en(1'b0), .flt_addr('0), .flt_bit(0), .flt_val(1'b0));

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int scr(input int a);
        return (a & ~1) | ((a & 1) ^ ((a >> 1) & 1));
    endfunction

    // Expected n-th write of a fault-free run
    function automatic int exp_addr(input int idx, input bit x, input bit s);
        int e, pos, l;
        bit up;
        e = idx / N;
        pos = idx % N;
        up = x ? (e < 2) : (e < 3);
        l = up ? pos : N - 1 - pos;
        return s ? scr(l) : l;
    endfunction

    function automatic logic [DW-1:0] exp_data(input int idx, input bit x);
        int e;
        bit one;
        e = idx / N;
        one = x ? (e == 1) : (e % 2 == 1);
        return one ? '1 : '0;
    endfunction

    bit mon_en = 1'b0;
    bit mon_x = 1'b0;
    int wr_cnt_s = 0, wr_err_s = 0, wr_cnt_f = 0, wr_err_f = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (we_s) begin
                if (int'(addr_s) != exp_addr(wr_cnt_s, mon_x, 1'b1) || wd_s != exp_data(wr_cnt_s, mon_x))
                    wr_err_s++;
                wr_cnt_s++;
            end
            if (we_f) begin
                if (int'(addr_f) != exp_addr(wr_cnt_f, mon_x, 1'b0) || wd_f != exp_data(wr_cnt_f, mon_x))
                    wr_err_f++;
                wr_cnt_f++;
            end
        end
    end

    bit first_ok;

    task automatic run_march(input bit x, input int mid_start, input bit mid_algo, output int cycles);
        @(negedge clk);
        algo_x = x;
        start = 1'b1;
        @(posedge clk);
        cycles = 1;
        @(negedge clk);
        start = 1'b0;
        first_ok = we_s && addr_s == '0 && wd_s == '0;
        if (mid_algo) algo_x = ~x;
        while (!done_s && cycles < LIMIT) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start = (cycles == mid_start);
        end
        start = 1'b0;
        algo_x = x;
        if (cycles >= LIMIT) chk(1'b0, "R3", "run timeout", cycles, LIMIT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_s == 0 && fail_s == 0, "R1", "done/fail in reset", {done_s, fail_s}, 0);
        chk(we_s == 0, "R1", "we in reset", we_s, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done_s == 0 && fail_s == 0 && we_s == 0 && fa_s == 0, "R1", "idle after reset", {done_s, fail_s, we_s}, 0);

        // March C- fault-free
        mon_en = 1'b1; mon_x = 1'b0;
        wr_cnt_s = 0; wr_err_s = 0; wr_cnt_f = 0; wr_err_f = 0;
        run_march(1'b0, 0, 1'b0, cyc);
        mon_en = 1'b0;
        chk(first_ok, "R2", "first fill write", first_ok, 1);
        chk(cyc == 11 * N + 1, "R3", "March C- length", cyc, 11 * N + 1);
        chk(done_s && !fail_s, "R3", "March C- pass", fail_s, 0);
        chk(wr_cnt_s == 5 * N, "R3", "March C- write count", wr_cnt_s, 5 * N);
        chk(wr_err_s == 0, "R5", "scrambled write order C-", wr_err_s, 0);
        chk(wr_err_f == 0 && wr_cnt_f == 5 * N, "R6", "flat write order C-", wr_err_f, 0);

        repeat (20) @(negedge clk);
        chk(done_s && !fail_s && !we_s, "R9", "pass held", done_s, 1);

        // March X fault-free
        mon_en = 1'b1; mon_x = 1'b1;
        wr_cnt_s = 0; wr_err_s = 0; wr_cnt_f = 0; wr_err_f = 0;
        run_march(1'b1, 0, 1'b0, cyc);
        mon_en = 1'b0;
        chk(cyc == 7 * N + 1, "R4", "March X length", cyc, 7 * N + 1);
        chk(done_s && !fail_s, "R4", "March X pass", fail_s, 0);
        chk(wr_cnt_s == 3 * N, "R4", "March X write count", wr_cnt_s, 3 * N);
        chk(wr_err_s == 0, "R5", "scrambled write order X", wr_err_s, 0);
        chk(wr_err_f == 0 && wr_cnt_f == 3 * N, "R6", "flat write order X", wr_err_f, 0);

        // R9 / R10: mid-run start and mode toggle ignored
        run_march(1'b0, 40, 1'b1, cyc);
        chk(cyc == 11 * N + 1, "R9", "mid-run start ignored", cyc, 11 * N + 1);
        chk(cyc == 11 * N + 1 && !fail_s, "R10", "mid-run mode toggle ignored", cyc, 11 * N + 1);

        // Stuck-at sweep over every physical word, both values, both modes
        for (int p = 0; p < N; p++) begin
            for (int v = 0; v < 2; v++) begin
                for (int x = 0; x < 2; x++) begin
                    int l, expc;
                    l = scr(p);
                    flt_en = 1'b1;
                    flt_addr = AW'(p);
                    flt_bit = (p * 3) % DW;
                    flt_val = v[0];
                    if (v == 1) expc = N + 2 * l + 3;
                    else if (x == 0) expc = 3 * N + 2 * l + 3;
                    else expc = 3 * N + 2 * (N - 1 - l) + 3;
                    run_march(x[0], 0, 1'b0, cyc);
                    chk(fail_s && done_s, "R7", "fault detected", fail_s, 1);
                    chk(cyc == expc, "R7", "detection cycle", cyc, expc);
                    chk(int'(fa_s) == l, "R8", "failing logical address", fa_s, l);
                    repeat (3) @(negedge clk);
                    chk(fail_s && int'(fa_s) == l && !we_s, "R9", "fail held, no writes", fa_s, l);
                end
            end
        end

        // Restart after fault removal clears the failure
        flt_en = 1'b0;
        run_march(1'b0, 0, 1'b0, cyc);
        chk(done_s && !fail_s && cyc == 11 * N + 1, "R9", "restart clears fail", fail_s, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule